// File: doc/BRIEF.md
# Burst Address Sequencer

This block sits in front of the array of a synchronous burst memory and supplies the word address for every beat of a four-beat burst. A burst begins when one of two active-low address strobes is asserted. One strobe belongs to the processor side and the other to the cache/memory controller side. On the clock edge that accepts a strobe, the block registers the external address and the state of the three chip enables. After that, a 2-bit beat counter replaces only the two low address bits. The counter moves forward while the active-low advance input is asserted and holds otherwise, which gives wait states.

A static order pin picks the burst order. In linear order the low bits count up and wrap modulo four. In interleaved order the low bits are the captured low bits XOR the beat number. The order pin is not registered, so the address output responds to it without a clock edge. A valid flag tells the array whether the captured chip-enable state selected this device. The first word therefore appears one registered stage after the strobe, and each following word needs one advance cycle. This fits the 3-1-1-1 access pattern of the memory around it.

Top module: `bseq_top`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `addr_valid`=0 and `word_addr`=0.
- R2: A strobe is accepted when `strobe_ctrl_n`=0, or when `strobe_proc_n`=0 and `ce_pipe_n`=0. After an accepted strobe, `word_addr` equals the `addr_in` sampled at that edge.
- R3: A processor-side strobe with `ce_pipe_n`=1 and no controller-side strobe is ignored. `word_addr` and `addr_valid` keep their previous values.
- R4: A controller-side strobe is always accepted. `addr_valid` becomes 1 only if `ce_pipe_n`=0, `ce_hi`=1 and `ce_lo_n`=0 at that edge. Otherwise it becomes 0, and the address is still captured.
- R5: With `order_linear`=1, the two low bits of `word_addr` are (captured low bits + beat) mod 4. The upper bits keep their captured value for the whole burst.
- R6: With `order_linear`=0, the two low bits of `word_addr` are the captured low bits XOR the beat number.
- R7: At an edge with no accepted strobe and `adv_n`=1, the beat does not move and `word_addr` holds.
- R8: When a strobe is accepted and `adv_n`=0 at the same edge, the strobe wins: the beat restarts at 0 and `word_addr` equals the new `addr_in`.
- R9: A change of `order_linear` changes `word_addr` with no clock edge in between.
- R10: After four advances the beat wraps, and `word_addr` is again the captured start address in both orders.
- R11: `addr_valid` changes only at an edge with an accepted strobe or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | AW | External start address |
| ce_pipe_n | input | 1 | Address-pipelining chip enable, active low |
| ce_hi | input | 1 | Depth-expansion chip enable, active high |
| ce_lo_n | input | 1 | Depth-expansion chip enable, active low |
| strobe_proc_n | input | 1 | Processor-side address strobe, active low |
| strobe_ctrl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_linear | input | 1 | Burst order: 1 linear, 0 interleaved (not clocked) |
| word_addr | output | AW | Current word address for the array |
| addr_valid | output | 1 | Device selected by the last accepted strobe |

## Verification
The checker tests several rules on every cycle. It confirms that an accepted strobe loads the sampled address even when advance is asserted with it. It confirms that `addr_valid` moves only on accepted strobes, and that a processor strobe blocked by the pipelining enable leaves the outputs alone. It also checks that the upper address bits never move during a burst and that an idle cycle with no advance holds the address. The exact beat sequences of the two orders, their wrap back to the start address, and the response of the address output to the order pin between edges can only be shown by the bench's directed scenarios.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  typedef enum logic {
    ORD_INTERLEAVE = 1'b0,
    ORD_LINEAR     = 1'b1
  } order_e;

  // Accept rule shared by capture logic: controller strobe always,
  // processor strobe only with the pipelining enable asserted.
  function automatic logic strobe_taken(input logic proc_n,
                                        input logic ctrl_n,
                                        input logic pipe_n);
    return (!ctrl_n) || (!proc_n && !pipe_n);
  endfunction

endpackage

// File: rtl/bseq_capture.sv
module bseq_capture #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_in,
  input  logic          ce_pipe_n,
  input  logic          ce_hi,
  input  logic          ce_lo_n,
  input  logic          strobe_proc_n,
  input  logic          strobe_ctrl_n,
  output logic          load,
  output logic [AW-1:0] base_q,
  output logic          sel_q
);
  import bseq_pkg::*;

  logic sel_now;

  assign load    = strobe_taken(strobe_proc_n, strobe_ctrl_n, ce_pipe_n);
  assign sel_now = !ce_pipe_n && ce_hi && !ce_lo_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      sel_q  <= 1'b0;
    end else if (load) begin
      base_q <= addr_in;
      sel_q  <= sel_now;
    end
  end

endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv_n,
  output logic [CW-1:0] beat_q
);

  always_ff @(posedge clk) begin
    if (rst || load) begin
      beat_q <= '0;              // strobe has priority over advance
    end else if (!adv_n) begin
      beat_q <= beat_q + 1'b1;   // natural wrap modulo 2**CW
    end
  end

endmodule

// File: rtl/bseq_order.sv
module bseq_order #(
  parameter int CW = 2
) (
  input  logic [CW-1:0] base_low,
  input  logic [CW-1:0] beat,
  input  logic          order_linear,
  output logic [CW-1:0] low_out
);
  import bseq_pkg::*;

  logic [CW-1:0] lin_sum;
  logic [CW-1:0] ilv_bits;

  assign lin_sum = base_low + beat;

  for (genvar i = 0; i < CW; i++) begin : g_ilv
    assign ilv_bits[i] = base_low[i] ^ beat[i];
  end

  assign low_out = (order_e'(order_linear) == ORD_LINEAR) ? lin_sum : ilv_bits;

endmodule

// File: rtl/bseq_top.sv
module bseq_top #(
  parameter int AW = 17,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_in,
  input  logic          ce_pipe_n,
  input  logic          ce_hi,
  input  logic          ce_lo_n,
  input  logic          strobe_proc_n,
  input  logic          strobe_ctrl_n,
  input  logic          adv_n,
  input  logic          order_linear,
  output logic [AW-1:0] word_addr,
  output logic          addr_valid
);
  localparam int UW = AW - CW;

  logic          load;
  logic [AW-1:0] base_q;
  logic          sel_q;
  logic [CW-1:0] beat_q;
  logic [CW-1:0] low_bits;

  bseq_capture #(.AW(AW)) u_cap (
    .clk(clk), .rst(rst), .addr_in(addr_in),
    .ce_pipe_n(ce_pipe_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
    .strobe_proc_n(strobe_proc_n), .strobe_ctrl_n(strobe_ctrl_n),
    .load(load), .base_q(base_q), .sel_q(sel_q)
  );

  bseq_beat_ctr #(.CW(CW)) u_ctr (
    .clk(clk), .rst(rst), .load(load), .adv_n(adv_n), .beat_q(beat_q)
  );

  // Order pin is static and unclocked: the low bits are a function of
  // registered state and the pin, so a pin change shows without an edge.
  bseq_order #(.CW(CW)) u_ord (
    .base_low(base_q[CW-1:0]), .beat(beat_q),
    .order_linear(order_linear), .low_out(low_bits)
  );

  assign word_addr  = {base_q[AW-1:CW], low_bits};
  assign addr_valid = sel_q;

  if (UW < 1) begin : g_bad_width
    initial $error("AW must exceed CW");
  end

endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
  parameter int AW = 17,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] addr_in,
  input logic          ce_pipe_n,
  input logic          strobe_proc_n,
  input logic          strobe_ctrl_n,
  input logic          adv_n,
  input logic          order_linear,
  input logic [AW-1:0] word_addr,
  input logic          addr_valid
);
  logic taken;
  assign taken = !strobe_ctrl_n || (!strobe_proc_n && !ce_pipe_n);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!addr_valid && word_addr == '0));

  // R2
  load_addr_chk: assert property (@(posedge clk) disable iff (rst)
    taken |=> word_addr == $past(addr_in));

  // R3
  proc_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe_proc_n && ce_pipe_n && strobe_ctrl_n && adv_n)
      |=> ($stable(addr_valid) && (order_linear != $past(order_linear) || $stable(word_addr))));

  // R5
  upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !taken |=> $stable(word_addr[AW-1:CW]));

  // R7
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!taken && adv_n) |=> (order_linear != $past(order_linear) || $stable(word_addr)));

  // R8
  strobe_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (taken && !adv_n) |=> word_addr == $past(addr_in));

  // R11
  valid_only_load_chk: assert property (@(posedge clk) disable iff (rst)
    !taken |=> $stable(addr_valid));

endmodule

bind bseq_top bseq_chk #(.AW(AW), .CW(CW)) u_chk (.*);

// File: tb/sim_bseq_top.sv
module sim_bseq_top;
  localparam int AW    = 17;
  localparam int CW    = 2;
  localparam int CLK_P = 10;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr_in;
  logic          ce_pipe_n, ce_hi, ce_lo_n;
  logic          strobe_proc_n, strobe_ctrl_n, adv_n, order_linear;
  logic [AW-1:0] word_addr;
  logic          addr_valid;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_P/2) clk = ~clk;

  bseq_top #(.AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .addr_in(addr_in),
    .ce_pipe_n(ce_pipe_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
    .strobe_proc_n(strobe_proc_n), .strobe_ctrl_n(strobe_ctrl_n),
    .adv_n(adv_n), .order_linear(order_linear),
    .word_addr(word_addr), .addr_valid(addr_valid)
  );

  function automatic logic [AW-1:0] model(input logic [AW-1:0] base,
                                          input int beat, input logic lin);
    logic [CW-1:0] lo;
    lo = lin ? CW'(base[CW-1:0] + beat) : (base[CW-1:0] ^ CW'(beat));
    return {base[AW-1:CW], lo};
  endfunction

  task automatic chk(input string req, input logic [AW-1:0] ea, input logic ev);
    total++;
    if (word_addr !== ea || addr_valid !== ev) begin
      bad++;
      $display("FAIL %s: addr=%h valid=%b expected addr=%h valid=%b",
               req, word_addr, addr_valid, ea, ev);
    end
  endtask

  // Drive one cycle's inputs at the falling edge, sample just after the rising edge.
  task automatic cyc(input logic pn, input logic cn, input logic an,
                     input logic [AW-1:0] a, input logic pipe_n = 1'b0,
                     input logic hi = 1'b1, input logic lo_n = 1'b0);
    @(negedge clk);
    strobe_proc_n = pn; strobe_ctrl_n = cn; adv_n = an;
    addr_in = a; ce_pipe_n = pipe_n; ce_hi = hi; ce_lo_n = lo_n;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    cyc(1, 1, 1, 17'h1FFFF);
    cyc(1, 1, 1, 17'h1FFFF);
    rst = 1'b0;
    chk("R1", '0, 1'b0);
  endtask

  task automatic t_burst(input logic lin, input logic [AW-1:0] base, input string req);
    order_linear = lin;
    cyc(1, 0, 1, base);
    chk("R2", base, 1'b1);
    for (int b = 1; b < 4; b++) begin
      cyc(1, 1, 0, 17'h0);
      chk(req, model(base, b, lin), 1'b1);  // R11 valid held through advances
    end
    cyc(1, 1, 0, 17'h0);
    chk("R10", base, 1'b1);
  endtask

  task automatic t_wait();
    logic [AW-1:0] base = 17'h0A5F2;
    order_linear = 1'b1;
    cyc(0, 1, 1, base);           // processor strobe, pipelining enable low
    chk("R2", base, 1'b1);
    cyc(1, 1, 0, 17'h0);
    cyc(1, 1, 1, 17'h0);
    cyc(1, 1, 1, 17'h0);
    chk("R7", model(base, 1, 1'b1), 1'b1);
    cyc(1, 1, 0, 17'h0);
    chk("R7", model(base, 2, 1'b1), 1'b1);
  endtask

  task automatic t_proc_ignore();
    logic [AW-1:0] base = 17'h04440;
    order_linear = 1'b1;
    cyc(1, 0, 1, base);
    cyc(0, 1, 1, 17'h1BBBB, 1'b1);  // blocked by ce_pipe_n high
    chk("R3", base, 1'b1);
  endtask

  task automatic t_ctrl_desel();
    cyc(1, 0, 1, 17'h13338, 1'b1);  // pipelining enable off
    chk("R4", 17'h13338, 1'b0);
    cyc(1, 0, 1, 17'h02224);
    chk("R4", 17'h02224, 1'b1);
    cyc(1, 0, 1, 17'h0777C, 1'b0, 1'b0, 1'b0); // ce_hi low
    chk("R4", 17'h0777C, 1'b0);
    cyc(1, 1, 0, 17'h0);
    chk("R11", model(17'h0777C, 1, order_linear), 1'b0);
  endtask

  task automatic t_priority();
    logic [AW-1:0] b2 = 17'h15A03;
    order_linear = 1'b0;
    cyc(1, 0, 1, 17'h00011);
    cyc(1, 1, 0, 17'h0);
    cyc(1, 0, 0, b2);               // strobe plus advance
    chk("R8", b2, 1'b1);
    cyc(1, 1, 0, 17'h0);
    chk("R8", model(b2, 1, 1'b0), 1'b1);
  endtask

  task automatic t_mode_async();
    logic [AW-1:0] base = 17'h00F01;
    order_linear = 1'b1;
    cyc(1, 0, 1, base);
    cyc(1, 1, 0, 17'h0);
    chk("R9", model(base, 1, 1'b1), 1'b1);   // low 01+1 = 10
    @(negedge clk);
    adv_n = 1'b1;
    order_linear = 1'b0;
    #1;
    chk("R9", model(base, 1, 1'b0), 1'b1);   // low 01^01 = 00
  endtask

  initial begin
    strobe_proc_n = 1; strobe_ctrl_n = 1; adv_n = 1; order_linear = 1;
    addr_in = '0; ce_pipe_n = 0; ce_hi = 1; ce_lo_n = 0; rst = 1;
    t_reset();
    t_burst(1'b1, 17'h12345, "R5");
    t_burst(1'b0, 17'h12345, "R6");
    t_burst(1'b0, 17'h0ABC2, "R6");
    t_wait();
    t_proc_ignore();
    t_ctrl_desel();
    t_priority();
    t_mode_async();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule